// File: doc/BRIEF.md
# Frame Strobe and Suspend Controller

This block turns the frame markers that the packet receiver recovers from the bus into a clean start-of-frame strobe for board logic. It also decides when the device drops into its low-power state. A counter clocked at 12 MHz re-aligns to every marker that arrives. If markers stop, the counter keeps producing one strobe every 12000 clocks, so the strobe stays at 1 ms and in phase with the last bus frame it saw.

The low-power output rises when the host asks for suspend or when the device is unplugged from the bus. A filtered auxiliary-enable pin vetoes that: while an analog source is attached, the block will not enter low power, and it leaves low power if a source appears. The same filtered pin drives the mixer select that adds the analog input. The converter path stays connected at all times and this block does not switch it.

The block wakes from low power on the first frame marker or when the request goes away, whichever happens first. After a wake caused by a marker, it stays awake until the request has been released once.

Top module: `frame_suspend_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, `sof_o`, `suspend_o` and `aux_sel_o` are all 0.
- R2: A marker sampled high on a clock edge drives `sof_o` high from the next cycle for exactly PULSE_CLKS cycles.
- R3: With no marker, a new strobe starts FRAME_CLKS cycles after the start of the previous one.
- R4: A marker arriving mid-frame restarts the period count from that marker, and the old phase does not strobe again. A marker that falls on the free-run wrap cycle gives one pulse of normal width, not two.
- R5: The auxiliary pin passes through a two-stage synchronizer. Its filtered value changes only after the synchronized level has differed from the filtered value for AUX_FILT_CLKS consecutive cycles. The output then follows AUX_FILT_CLKS+1 edges after the first edge that samples the new pin level. Shorter pulses are ignored.
- R6: `aux_sel_o` is the filtered auxiliary level. 1 means the analog input is added to the mix.
- R7: With the filtered auxiliary level at 0 and no marker in that cycle, `suspend_o` rises on the edge after `susp_req_i`=1 or `bus_conn_i`=0 is sampled.
- R8: While the filtered auxiliary level is 1, `suspend_o` never rises. If it becomes 1 while suspended, `suspend_o` falls on the next edge.
- R9: A marker while suspended clears `suspend_o` on the next edge. The block then stays awake until the request is released (`susp_req_i`=0 and `bus_conn_i`=1). A marker in the same cycle as the entry condition prevents entry for that cycle.
- R10: While suspended, sampling `susp_req_i`=0 with `bus_conn_i`=1 clears `suspend_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_mark_i | input | 1 | One-cycle pulse from the packet receiver for each received frame |
| susp_req_i | input | 1 | Host has idled the bus and requests low power |
| bus_conn_i | input | 1 | 1 while the device is attached to the bus |
| aux_en_i | input | 1 | Asynchronous auxiliary-source pin, 1 = source attached |
| sof_o | output | 1 | Start-of-frame strobe, high PULSE_CLKS cycles per frame |
| suspend_o | output | 1 | 0 = normal power, 1 = low power |
| aux_sel_o | output | 1 | Mixer select, 1 = add the analog auxiliary input |

## Verification
The frame marker serves two functions in one cycle. It re-aligns the strobe, and it is the bus activity that wakes or blocks suspend. The bench therefore drives a marker exactly on the free-run wrap cycle and checks that the strobe makes one normal-width pulse with the period measured from that edge. It also drives a marker in the very cycle the suspend entry condition first holds, and checks that `suspend_o` stays low there and rises only on the following cycle once the marker has gone.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  // Power-state machine encoding
  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,  // normal power, entry allowed
    PWR_SLEEP = 2'd1,  // low-power state, SUSPEND driven high
    PWR_HOLD  = 2'd2   // woken by bus activity, waiting for request release
  } pwr_state_t;

endpackage

// File: rtl/fsc_frame_timer.sv
module fsc_frame_timer #(
  parameter int FRAME_CLKS = 12000,
  parameter int PULSE_CLKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic mark_i,
  output logic sof_o
);

  localparam int CW = $clog2(FRAME_CLKS);
  localparam int PW = $clog2(PULSE_CLKS + 1);
  localparam logic [CW-1:0] CNT_LAST  = CW'(FRAME_CLKS - 1);
  localparam logic [PW-1:0] PLEN_INIT = PW'(PULSE_CLKS - 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] plen_q;
  logic          sof_q;
  logic          frame_start;

  // a received marker wins; otherwise the counter wraps on its own
  assign frame_start = mark_i || (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      plen_q <= '0;
      sof_q  <= 1'b0;
    end else if (frame_start) begin
      cnt_q  <= '0;
      plen_q <= PLEN_INIT;
      sof_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (plen_q != '0) begin
        plen_q <= plen_q - 1'b1;
      end else begin
        sof_q <= 1'b0;
      end
    end
  end

  assign sof_o = sof_q;

  AST_MARK_STROBE: assert property (@(posedge clk) disable iff (rst)
    mark_i |=> sof_q);  // R2
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_LAST) |=> sof_q);  // R3
  AST_MARK_REALIGN: assert property (@(posedge clk) disable iff (rst)
    mark_i |=> (cnt_q == '0));  // R4

endmodule

// File: rtl/fsc_aux_filter.sv
module fsc_aux_filter #(
  parameter int SYNC_STAGES   = 2,
  parameter int AUX_FILT_CLKS = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic aux_pin_i,
  output logic aux_on_o
);

  localparam int FW = $clog2(AUX_FILT_CLKS);
  localparam logic [FW-1:0] FILT_LAST = FW'(AUX_FILT_CLKS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   level_s;
  logic [FW-1:0]          stab_q;
  logic                   aux_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      assign sync_d = {sync_q[SYNC_STAGES-2:0], aux_pin_i};
    end else begin : g_single
      assign sync_d = aux_pin_i;
    end
  endgenerate

  assign level_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      stab_q <= '0;
      aux_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      if (level_s == aux_q) begin
        stab_q <= '0;
      end else if (stab_q == FILT_LAST) begin
        aux_q  <= level_s;
        stab_q <= '0;
      end else begin
        stab_q <= stab_q + 1'b1;
      end
    end
  end

  assign aux_on_o = aux_q;

  AST_AUX_SETTLED: assert property (@(posedge clk) disable iff (rst)
    !$stable(aux_q) |-> ((aux_q == $past(level_s)) && ($past(stab_q) == FILT_LAST)));  // R5

endmodule

// File: rtl/fsc_power_fsm.sv
module fsc_power_fsm
  import fsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic susp_req_i,
  input  logic bus_conn_i,
  input  logic aux_on_i,
  output logic suspend_o
);

  pwr_state_t st_q, st_d;
  logic       want_low;
  logic       susp_q;

  assign want_low = susp_req_i || !bus_conn_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PWR_RUN:   if (want_low && !aux_on_i && !act_i) st_d = PWR_SLEEP;
      PWR_SLEEP: begin
        if (!want_low || aux_on_i) st_d = PWR_RUN;
        else if (act_i)            st_d = PWR_HOLD;
      end
      PWR_HOLD:  if (!want_low) st_d = PWR_RUN;
      default:   st_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PWR_RUN;
      susp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      susp_q <= (st_d == PWR_SLEEP);
    end
  end

  assign suspend_o = susp_q;

  AST_SUSP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_q) |-> $past(susp_req_i || !bus_conn_i));  // R7
  AST_SUSP_VETO: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_q) |-> !$past(aux_on_i));  // R8
  AST_SUSP_AUX_EXIT: assert property (@(posedge clk) disable iff (rst)
    (susp_q && aux_on_i) |=> !susp_q);  // R8
  AST_SUSP_WAKE: assert property (@(posedge clk) disable iff (rst)
    (susp_q && act_i) |=> !susp_q);  // R9
  AST_SUSP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (susp_q && !susp_req_i && bus_conn_i) |=> !susp_q);  // R10

endmodule

// File: rtl/frame_suspend_ctrl.sv
module frame_suspend_ctrl #(
  parameter int FRAME_CLKS    = 12000,
  parameter int PULSE_CLKS    = 12,
  parameter int SYNC_STAGES   = 2,
  parameter int AUX_FILT_CLKS = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_mark_i,
  input  logic susp_req_i,
  input  logic bus_conn_i,
  input  logic aux_en_i,
  output logic sof_o,
  output logic suspend_o,
  output logic aux_sel_o
);

  logic aux_on;

  fsc_frame_timer #(
    .FRAME_CLKS (FRAME_CLKS),
    .PULSE_CLKS (PULSE_CLKS)
  ) u_timer (
    .clk    (clk),
    .rst    (rst),
    .mark_i (frame_mark_i),
    .sof_o  (sof_o)
  );

  fsc_aux_filter #(
    .SYNC_STAGES   (SYNC_STAGES),
    .AUX_FILT_CLKS (AUX_FILT_CLKS)
  ) u_aux (
    .clk       (clk),
    .rst       (rst),
    .aux_pin_i (aux_en_i),
    .aux_on_o  (aux_on)
  );

  fsc_power_fsm u_pwr (
    .clk        (clk),
    .rst        (rst),
    .act_i      (frame_mark_i),
    .susp_req_i (susp_req_i),
    .bus_conn_i (bus_conn_i),
    .aux_on_i   (aux_on),
    .suspend_o  (suspend_o)
  );

  assign aux_sel_o = aux_on;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!sof_o && !suspend_o && !aux_sel_o));  // R1

endmodule

// File: tb/test_frame_suspend_ctrl.sv
module test_frame_suspend_ctrl;

  localparam int N = 100;
  localparam int P = 4;
  localparam int F = 20;

  // vector bits: [3] susp_req [2] bus_conn [1] frame_mark [0] expected suspend
  localparam logic [3:0] VEC [0:12] = '{
    4'b0100, 4'b1101, 4'b1101, 4'b1110, 4'b1100, 4'b0100, 4'b1101,
    4'b0100, 4'b0001, 4'b0100, 4'b1110, 4'b1101, 4'b0100
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mark = 1'b0, req = 1'b0, conn = 1'b1, aux = 1'b0;
  logic sof, susp, asel;
  int   n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  frame_suspend_ctrl #(
    .FRAME_CLKS (N), .PULSE_CLKS (P), .SYNC_STAGES (2), .AUX_FILT_CLKS (F)
  ) i_frame_suspend_ctrl (
    .clk (clk), .rst (rst), .frame_mark_i (mark), .susp_req_i (req),
    .bus_conn_i (conn), .aux_en_i (aux),
    .sof_o (sof), .suspend_o (susp), .aux_sel_o (asel)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_mark();
    @(negedge clk) mark = 1'b1;
    @(negedge clk) mark = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_n(5);
    chk("R1 sof in reset", sof, 1'b0);
    chk("R1 suspend in reset", susp, 1'b0);
    chk("R1 aux_sel in reset", asel, 1'b0);
    rst = 1'b0;
    wait_n(1);
    chk("R1 sof after reset", sof, 1'b0);

    // R2 pulse width, R3 free-run period
    pulse_mark();
    chk("R2 pulse start", sof, 1'b1);
    for (int k = 1; k < P; k++) begin
      wait_n(1);
      chk("R2 pulse held", sof, 1'b1);
    end
    wait_n(1);
    chk("R2 pulse end", sof, 1'b0);
    wait_n(N - 1 - P);
    chk("R3 before wrap", sof, 1'b0);
    wait_n(1);
    chk("R3 free-run strobe", sof, 1'b1);
    wait_n(N - 1);
    chk("R3 before second wrap", sof, 1'b0);
    wait_n(1);
    chk("R3 second free-run strobe", sof, 1'b1);

    // R4 mid-frame realign
    wait_n(39);
    pulse_mark();
    chk("R4 realign strobe", sof, 1'b1);
    wait_n(59);
    chk("R4 old phase silent", sof, 1'b0);
    wait_n(N - 60);
    chk("R4 before new wrap", sof, 1'b0);
    wait_n(1);
    chk("R4 strobe on new phase", sof, 1'b1);

    // R4 marker coinciding with wrap
    wait_n(N - 2);
    pulse_mark();
    chk("R4 coincide strobe", sof, 1'b1);
    wait_n(P - 1);
    chk("R4 coincide last cycle", sof, 1'b1);
    wait_n(1);
    chk("R4 coincide single pulse", sof, 1'b0);
    wait_n(N - P - 1);
    chk("R4 coincide period low", sof, 1'b0);
    wait_n(1);
    chk("R4 coincide period strobe", sof, 1'b1);

    // R7 R9 R10 vector walk, one cycle per row
    foreach (VEC[i]) begin
      @(negedge clk);
      req  = VEC[i][3];
      conn = VEC[i][2];
      mark = VEC[i][1];
      @(posedge clk);
      #1;
      chk($sformatf("R7 R9 R10 vector %0d", i), susp, VEC[i][0]);
    end
    @(negedge clk) begin mark = 1'b0; req = 1'b0; conn = 1'b1; end

    // R5 short glitch ignored
    aux = 1'b1;
    wait_n(F / 2);
    aux = 1'b0;
    wait_n(F + 10);
    chk("R5 glitch ignored", asel, 1'b0);

    // R5 R6 filtered rise timing
    aux = 1'b1;
    wait_n(F);
    chk("R5 not yet settled", asel, 1'b0);
    wait_n(3);
    chk("R6 mixer select on", asel, 1'b1);

    // R8 veto while aux present
    req = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_n(1);
      chk("R8 entry vetoed", susp, 1'b0);
    end
    aux = 1'b0;
    wait_n(F);
    chk("R5 fall not yet settled", asel, 1'b1);
    wait_n(3);
    chk("R6 mixer select off", asel, 1'b0);
    chk("R7 entry after aux gone", susp, 1'b1);

    // R8 exit on aux arrival
    aux = 1'b1;
    wait_n(F);
    chk("R8 still suspended", susp, 1'b1);
    wait_n(3);
    chk("R8 aux wakes", susp, 1'b0);

    // R5 glitch low while aux held on
    aux = 1'b0;
    wait_n(F / 2);
    aux = 1'b1;
    wait_n(F + 10);
    chk("R5 low glitch ignored", asel, 1'b1);
    chk("R8 stays awake", susp, 1'b0);

    req = 1'b0;
    wait_n(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule